// File: doc/BRIEF.md
# Load Address Generator with Result Extension

This block sits between the register read stage and the data memory port of a 32-bit core. For each load it takes the operand register values, the mode and size codes and a compact offset field, and works out the effective address, the access width presented to memory and, for stack pops, the new value of the stack pointer. The offset field holds displacements already divided by the access width, and the block scales them back. A second path takes the word returned by memory and turns it into the 32-bit load result. It picks the addressed byte or halfword lane in big-endian order and pads the upper bits with zeros. When a pop targets the status register, it also produces a flag-update strobe.

Both paths are streams with one register stage each. An upstream producer offers a transaction with a valid signal. The stage takes it when its ready output is high, which is true whenever the stage is empty or its own consumer takes the held entry in the same cycle. A stage whose consumer holds ready low keeps its output valid and unchanged. Producers must keep valid and payload steady until the transfer completes. The two paths are independent, so address generation for one load can overlap the formatting of an earlier load's data.

Top module: `load_addr_gen`

## Requirements
- R1: Mode code 0 (register indirect) gives an address equal to `req_rj`; mode codes 5 to 7 behave the same way.
- R2: Mode code 1 (indexed) gives an address equal to `req_r13 + req_rj`, wrapping modulo 2^32.
- R3: Mode code 2 (frame-relative) sign-extends the 8-bit `req_off` to 32 bits and scales it by the size: ×4 for size code 2 (word) or 3, ×2 for size code 1 (halfword), ×1 for size code 0 (byte). The result is added to `req_r14`.
- R4: Mode code 3 (stack-relative) takes `req_off[3:0]` as an unsigned count, multiplies it by 4 and adds it to `req_r15`. `req_off[7:4]` is ignored, and the access size is word whatever `req_size` says.
- R5: Mode code 4 (pop) presents `req_r15` as the address with word size, raises `a_r15_we` and gives `a_r15_next = req_r15 + 4`. Every other mode gives `a_r15_we = 0` and `a_r15_next = req_r15`.
- R6: An accepted request appears on the address outputs in the next cycle. `req_ready` equals `!a_valid || a_ready`, and a result held with `a_ready` low stays valid and unchanged.
- R7: Response size code 0 returns byte lane `rsp_lane`, where lane 0 is `rsp_data[31:24]` and lane 3 is `rsp_data[7:0]`, zero-extended to 32 bits.
- R8: Response size code 1 returns `rsp_data[31:16]` when `rsp_lane[1]` is 0 and `rsp_data[15:0]` when it is 1, zero-extended to 32 bits.
- R9: Response size codes 2 and 3 return `rsp_data` unchanged.
- R10: `ld_flags_we` equals the `rsp_to_flags` of the response it belongs to. When it is set, `ld_flags` carries `rsp_data[3:0]`; otherwise `ld_flags` is zero.
- R11: An accepted response appears on the load outputs in the next cycle. `rsp_ready` equals `!ld_valid || ld_ready`, and a result held with `ld_ready` low stays valid and unchanged.
- R12: During and immediately after reset, `a_valid` and `ld_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_mode | input | 3 | Addressing mode code |
| req_size | input | 2 | Access size code (0 byte, 1 halfword, 2/3 word) |
| req_rj | input | 32 | General index/indirect register value |
| req_r13 | input | 32 | Index base register value |
| req_r14 | input | 32 | Frame base register value |
| req_r15 | input | 32 | Stack pointer value |
| req_off | input | 8 | Pre-divided offset field |
| a_valid | output | 1 | Address result valid |
| a_ready | input | 1 | Memory side takes the address result |
| a_addr | output | 32 | Effective address |
| a_size | output | 2 | Access size sent to memory |
| a_r15_we | output | 1 | Stack pointer update strobe |
| a_r15_next | output | 32 | Updated stack pointer value |
| rsp_valid | input | 1 | Memory data offered |
| rsp_ready | output | 1 | Memory data accepted when high with rsp_valid |
| rsp_data | input | 32 | Raw 32-bit memory word |
| rsp_size | input | 2 | Size code of the load |
| rsp_lane | input | 2 | Low address bits of the load |
| rsp_to_flags | input | 1 | Load is a pop into the status register |
| ld_valid | output | 1 | Load result valid |
| ld_ready | input | 1 | Writeback takes the load result |
| ld_data | output | 32 | Extended load result |
| ld_flags_we | output | 1 | Condition flag update strobe |
| ld_flags | output | 4 | Condition flags from memory |

## Verification
The bench pushes offset fields of 0x00, 0x7F, 0x80 and 0xFF through the frame-relative mode at every size. A design that zero-extends instead of sign-extending, or that scales by the wrong width, produces addresses far above the base where they should sit below it. Stack-relative requests carry junk in the upper offset nibble and a halfword size code, so a design that reads all 8 bits or trusts the size code is caught. Pops start from stack values near 0xFFFFFFFC to show the wrap of the increment. Byte and halfword data cover all four lanes with distinct byte patterns, so a little-endian lane pick or a sign fill shows up at once. Random back-pressure on both outputs exposes any stage that drops, repeats or alters a held result.

// File: rtl/lag_pkg.sv
package lag_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    AM_IND  = 3'd0,
    AM_IDX  = 3'd1,
    AM_FRM  = 3'd2,
    AM_STK  = 3'd3,
    AM_POP  = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD3 = 2'd3
  } asize_e;

  typedef struct packed {
    logic [XLEN-1:0] addr;
    logic [1:0]      size;
    logic            sp_we;
    logic [XLEN-1:0] sp_next;
  } agen_res_t;

  typedef struct packed {
    logic [XLEN-1:0] data;
    logic            flg_we;
    logic [3:0]      flg;
  } ldfmt_res_t;
endpackage

// File: rtl/lag_stage.sv
module lag_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      dat_q <= in_data;
    end
  end
endmodule

// File: rtl/lag_addr_calc.sv
module lag_addr_calc
  import lag_pkg::*;
#(
  parameter int OFF_W    = 8,
  parameter int STK_W    = 4,
  parameter int POP_STEP = 4
) (
  input  logic [2:0]      mode,
  input  logic [1:0]      size,
  input  logic [XLEN-1:0] rj,
  input  logic [XLEN-1:0] r13,
  input  logic [XLEN-1:0] r14,
  input  logic [XLEN-1:0] r15,
  input  logic [OFF_W-1:0] off,
  output agen_res_t       res
);
  localparam int SEXT_W = XLEN - OFF_W;
  localparam int ZEXT_W = XLEN - STK_W;

  logic [XLEN-1:0] off_sext;
  logic [XLEN-1:0] off_scaled;
  logic [XLEN-1:0] stk_disp;

  assign off_sext = {{SEXT_W{off[OFF_W-1]}}, off};
  assign stk_disp = {{ZEXT_W{1'b0}}, off[STK_W-1:0]} << 2;

  always_comb begin
    unique case (asize_e'(size))
      SZ_BYTE: off_scaled = off_sext;
      SZ_HALF: off_scaled = off_sext << 1;
      default: off_scaled = off_sext << 2;
    endcase
  end

  always_comb begin
    res.addr    = rj;
    res.size    = size;
    res.sp_we   = 1'b0;
    res.sp_next = r15;
    case (mode)
      AM_IDX: res.addr = r13 + rj;
      AM_FRM: res.addr = r14 + off_scaled;
      AM_STK: begin
        res.addr = r15 + stk_disp;
        res.size = SZ_WORD;
      end
      AM_POP: begin
        res.addr    = r15;
        res.size    = SZ_WORD;
        res.sp_we   = 1'b1;
        res.sp_next = r15 + XLEN'(POP_STEP);
      end
      default: res.addr = rj;
    endcase
  end
endmodule

// File: rtl/lag_extend.sv
module lag_extend
  import lag_pkg::*;
#(
  parameter int FLG_W = 4
) (
  input  logic [XLEN-1:0] data,
  input  logic [1:0]      size,
  input  logic [1:0]      lane,
  input  logic            to_flags,
  output ldfmt_res_t      res
);
  localparam int NLANE = XLEN / 8;
  localparam int HALF  = XLEN / 2;

  logic [7:0]      lane_byte [NLANE];
  logic [XLEN-1:0] byte_ext;
  logic [XLEN-1:0] half_ext;

  // big-endian: lane 0 is the most significant byte
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_byte[g] = data[XLEN-1-8*g -: 8];
  end

  assign byte_ext = {{(XLEN-8){1'b0}}, lane_byte[lane]};
  assign half_ext = lane[1] ? {{HALF{1'b0}}, data[HALF-1:0]}
                            : {{HALF{1'b0}}, data[XLEN-1:HALF]};

  always_comb begin
    unique case (asize_e'(size))
      SZ_BYTE: res.data = byte_ext;
      SZ_HALF: res.data = half_ext;
      default: res.data = data;
    endcase
    res.flg_we = to_flags;
    res.flg    = to_flags ? data[FLG_W-1:0] : '0;
  end
endmodule

// File: rtl/load_addr_gen.sv
module load_addr_gen
  import lag_pkg::*;
#(
  parameter int OFF_W    = 8,
  parameter int STK_W    = 4,
  parameter int POP_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_mode,
  input  logic [1:0]       req_size,
  input  logic [XLEN-1:0]  req_rj,
  input  logic [XLEN-1:0]  req_r13,
  input  logic [XLEN-1:0]  req_r14,
  input  logic [XLEN-1:0]  req_r15,
  input  logic [OFF_W-1:0] req_off,
  output logic             a_valid,
  input  logic             a_ready,
  output logic [XLEN-1:0]  a_addr,
  output logic [1:0]       a_size,
  output logic             a_r15_we,
  output logic [XLEN-1:0]  a_r15_next,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [XLEN-1:0]  rsp_data,
  input  logic [1:0]       rsp_size,
  input  logic [1:0]       rsp_lane,
  input  logic             rsp_to_flags,
  output logic             ld_valid,
  input  logic             ld_ready,
  output logic [XLEN-1:0]  ld_data,
  output logic             ld_flags_we,
  output logic [3:0]       ld_flags
);
  localparam int AW = $bits(agen_res_t);
  localparam int LW = $bits(ldfmt_res_t);

  agen_res_t  agen_d, agen_q;
  ldfmt_res_t fmt_d,  fmt_q;

  lag_addr_calc #(
    .OFF_W(OFF_W), .STK_W(STK_W), .POP_STEP(POP_STEP)
  ) u_calc (
    .mode(req_mode), .size(req_size), .rj(req_rj), .r13(req_r13),
    .r14(req_r14), .r15(req_r15), .off(req_off), .res(agen_d)
  );

  lag_stage #(.W(AW)) u_astage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(agen_d),
    .out_valid(a_valid), .out_ready(a_ready), .out_data(agen_q)
  );

  lag_extend #(.FLG_W(4)) u_ext (
    .data(rsp_data), .size(rsp_size), .lane(rsp_lane),
    .to_flags(rsp_to_flags), .res(fmt_d)
  );

  lag_stage #(.W(LW)) u_lstage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rsp_valid), .in_ready(rsp_ready), .in_data(fmt_d),
    .out_valid(ld_valid), .out_ready(ld_ready), .out_data(fmt_q)
  );

  assign a_addr      = agen_q.addr;
  assign a_size      = agen_q.size;
  assign a_r15_we    = agen_q.sp_we;
  assign a_r15_next  = agen_q.sp_next;
  assign ld_data     = fmt_q.data;
  assign ld_flags_we = fmt_q.flg_we;
  assign ld_flags    = fmt_q.flg;
endmodule

// File: rtl/lag_checker.sv
module lag_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_mode,
  input logic        a_valid,
  input logic        a_ready,
  input logic [31:0] a_addr,
  input logic [1:0]  a_size,
  input logic        a_r15_we,
  input logic [31:0] a_r15_next,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [1:0]  rsp_size,
  input logic        ld_valid,
  input logic        ld_ready,
  input logic [31:0] ld_data,
  input logic        ld_flags_we,
  input logic [3:0]  ld_flags
);
  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && a_r15_we |-> (a_r15_next == a_addr + 32'd4) && (a_size == 2'd2));

  p_stk_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_mode == 3'd3 |=> a_size == 2'd2);

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> a_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && !a_ready |=> a_valid && $stable(a_addr) && $stable(a_size)
                            && $stable(a_r15_next) && $stable(a_r15_we));

  p_empty_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !a_valid |-> req_ready);

  p_byte_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_size == 2'd0 |=> ld_data[31:8] == 24'd0);

  p_half_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_size == 2'd1 |=> ld_data[31:16] == 16'd0);

  p_flags_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_flags_we |-> ld_flags == 4'd0);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_ready |=> ld_valid && $stable(ld_data) && $stable(ld_flags)
                              && $stable(ld_flags_we));

  p_reset_r12: assert property (@(posedge clk)
    !rst_n |-> !a_valid && !ld_valid);
endmodule

bind load_addr_gen lag_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mode(req_mode), .a_valid(a_valid), .a_ready(a_ready), .a_addr(a_addr),
  .a_size(a_size), .a_r15_we(a_r15_we), .a_r15_next(a_r15_next),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_size(rsp_size),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
  .ld_flags_we(ld_flags_we), .ld_flags(ld_flags)
);

// File: tb/load_addr_gen_bench.sv
`timescale 1ns/1ps
module load_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_mode = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_rj = '0, req_r13 = '0, req_r14 = '0, req_r15 = '0;
  logic [7:0]  req_off = '0;
  logic        a_valid, a_ready = 1'b0, a_r15_we;
  logic [31:0] a_addr, a_r15_next;
  logic [1:0]  a_size;
  logic        rsp_valid = 1'b0, rsp_ready, rsp_to_flags = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [1:0]  rsp_size = '0, rsp_lane = '0;
  logic        ld_valid, ld_ready = 1'b0, ld_flags_we;
  logic [31:0] ld_data;
  logic [3:0]  ld_flags;

  always #2 clk = ~clk;  // 250 MHz

  load_addr_gen u_load_addr_gen (.*);

  typedef struct { logic [31:0] addr; logic [1:0] size; logic we; logic [31:0] nxt; string tag; } aexp_t;
  typedef struct { logic [31:0] data; logic we; logic [3:0] flg; string tag; } lexp_t;
  aexp_t aq[$];
  lexp_t lq[$];
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic aexp_t model_a(input logic [2:0] m, input logic [1:0] s,
      input logic [31:0] rj, r13, r14, r15, input logic [7:0] off);
    aexp_t e;
    int so;
    e.size = s; e.we = 0; e.nxt = r15; e.addr = rj; e.tag = "R1";
    so = int'($signed(off));
    case (m)
      3'd1: begin e.addr = r13 + rj; e.tag = "R2"; end
      3'd2: begin
        e.addr = r14 + 32'(so * (s == 2'd0 ? 1 : (s == 2'd1 ? 2 : 4)));
        e.tag = "R3";
      end
      3'd3: begin e.addr = r15 + 32'(int'(off % 16) * 4); e.size = 2'd2; e.tag = "R4"; end
      3'd4: begin e.addr = r15; e.size = 2'd2; e.we = 1; e.nxt = r15 + 32'd4; e.tag = "R5"; end
      default: ;
    endcase
    return e;
  endfunction

  function automatic lexp_t model_l(input logic [31:0] d, input logic [1:0] s,
      input logic [1:0] ln, input logic tf);
    lexp_t e;
    if (s == 2'd0) begin e.data = (d >> (8 * (3 - int'(ln)))) & 32'hFF; e.tag = "R7"; end
    else if (s == 2'd1) begin e.data = ln[1] ? (d & 32'hFFFF) : (d >> 16); e.tag = "R8"; end
    else begin e.data = d; e.tag = "R9"; end
    e.we = tf; e.flg = tf ? d[3:0] : 4'd0;
    return e;
  endfunction

  function automatic logic [7:0] pick_off();
    case ($urandom_range(0, 5))
      0: return 8'h00;
      1: return 8'h7F;
      2: return 8'h80;
      3: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    bit rq_hs, rs_hs;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    chk(!a_valid && !ld_valid, "R12 reset valids", {a_valid, ld_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!a_valid && !ld_valid, "R12 after reset", {a_valid, ld_valid}, 0);
    chk(req_ready && rsp_ready, "R6/R11 ready when empty", {req_ready, rsp_ready}, 2'b11);
    rq_hs = 0; rs_hs = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      // outputs settled after previous edge: compare with model
      chk(a_valid == (aq.size() > 0), "R6 a_valid vs model", a_valid, aq.size() > 0);
      if (a_valid && aq.size() > 0) begin
        chk(a_addr == aq[0].addr, {aq[0].tag, " addr"}, a_addr, aq[0].addr);
        chk(a_size == aq[0].size, {aq[0].tag, " size"}, a_size, aq[0].size);
        chk(a_r15_we == aq[0].we && a_r15_next == aq[0].nxt, "R5 r15 update",
            {a_r15_we, a_r15_next}, {aq[0].we, aq[0].nxt});
      end
      chk(ld_valid == (lq.size() > 0), "R11 ld_valid vs model", ld_valid, lq.size() > 0);
      if (ld_valid && lq.size() > 0) begin
        chk(ld_data == lq[0].data, {lq[0].tag, " data"}, ld_data, lq[0].data);
        chk(ld_flags_we == lq[0].we && ld_flags == lq[0].flg, "R10 flags",
            {ld_flags_we, ld_flags}, {lq[0].we, lq[0].flg});
      end
      // new stimulus, keeping any offer not yet taken
      if (!(req_valid && !rq_hs)) begin
        req_valid = ($urandom_range(0, 9) < 6);
        req_mode  = 3'($urandom_range(0, 7));
        req_size  = 2'($urandom);
        req_rj    = $urandom; req_r13 = $urandom; req_r14 = $urandom;
        req_r15   = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFC : ($urandom & 32'hFFFF_FFFC);
        req_off   = pick_off();
      end
      if (!(rsp_valid && !rs_hs)) begin
        rsp_valid    = ($urandom_range(0, 9) < 6);
        rsp_data     = $urandom | 32'h8080_8080;
        rsp_size     = 2'($urandom);
        rsp_lane     = 2'($urandom);
        rsp_to_flags = ($urandom_range(0, 4) == 0);
      end
      a_ready  = ($urandom_range(0, 9) < 7);
      ld_ready = ($urandom_range(0, 9) < 7);
      #1;
      chk(req_ready == (!a_valid || a_ready), "R6 req_ready rule", req_ready, !a_valid || a_ready);
      chk(rsp_ready == (!ld_valid || ld_ready), "R11 rsp_ready rule", rsp_ready, !ld_valid || ld_ready);
      rq_hs = req_valid && req_ready;
      rs_hs = rsp_valid && rsp_ready;
      if (a_valid && a_ready && aq.size() > 0) void'(aq.pop_front());
      if (ld_valid && ld_ready && lq.size() > 0) void'(lq.pop_front());
      if (rq_hs) aq.push_back(model_a(req_mode, req_size, req_rj, req_r13, req_r14, req_r15, req_off));
      if (rs_hs) lq.push_back(model_l(rsp_data, rsp_size, rsp_lane, rsp_to_flags));
      @(negedge clk);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule